// File: doc/BRIEF.md
# Queued Interrupt Entry Controller

This block decides when and how the processor enters an interrupt handler. Interrupt messages of 16 bits arrive from software (an interrupt instruction) and from hardware devices, and are written into a first-in first-out queue. The block holds the handler address register and a hold flag. Whenever the core signals that it sits between two instructions, the block may remove one message from the queue and start an entry sequence. The sequence asks the core to write the current program counter to the stack and then the current accumulator, and finally gives the core a new program counter (the handler address) and a new accumulator (the message).

Taking an interrupt sets the hold flag, so nested entries are blocked until the handler returns. A return-from-interrupt command clears the flag. Software can also set or clear it directly. Messages keep entering the queue while the flag is set. The check on the handler address is made when a message leaves the queue. If the address is zero at that moment, the message is thrown away and no entry sequence runs. If the queue is full, further messages are lost and a sticky overflow flag is raised.

Top module: `irq_queue_ctrl`

## Requirements
- R1: After reset, `stackPushReq`, `loadValid`, `inService` and `overflow` are 0, and `iaValue` is 0.
- R2: A cycle with `iasValid` high loads `iasData` into the handler address, and `iaValue` shows the new value from the next cycle on.
- R3: The queue holds DEPTH (default 256) messages. A message that arrives when no slot is free is discarded, and `overflow` rises and stays at 1 until reset.
- R4: Messages leave the queue in arrival order. When a software and a hardware message arrive in the same cycle, the software message is placed ahead of the hardware message.
- R5: A message is removed only in a cycle where `atBoundary` is high, no entry sequence is running, the queue is not empty and the hold flag is clear. At most one message is removed per such cycle.
- R6: An entry sequence first raises `stackPushReq` with `stackPushData` equal to the `pcIn` sampled at removal. It then raises it with the `aIn` sampled at removal. Each write ends on a cycle with `stackAck` high, and request and data stay stable while the acknowledge is low. After the second write, `loadValid` is high for exactly one cycle, with `newPc` equal to the handler address and `newA` equal to the message.
- R7: Starting an entry sequence sets the hold flag. While the flag is set, later boundaries remove nothing, and messages are still queued.
- R8: A cycle with `rfiValid` high clears the hold flag.
- R9: A cycle with `iaqValid` high sets the hold flag if `iaqArg` is nonzero and clears it if `iaqArg` is zero.
- R10: A message removed while the handler address is zero is discarded: no stack write and no load follow, and the message is not dispatched later.
- R11: The handler address is checked when a message is removed, not when it arrives. A message queued while the address was zero is dispatched if the address is nonzero when the message is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| swPush | input | 1 | Software interrupt message valid |
| swMsg | input | 16 | Software interrupt message |
| hwPush | input | 1 | Hardware interrupt message valid |
| hwMsg | input | 16 | Hardware interrupt message |
| atBoundary | input | 1 | Core is between instructions and can accept an entry |
| pcIn | input | 16 | Current program counter of the core |
| aIn | input | 16 | Current accumulator of the core |
| iasValid | input | 1 | Write the handler address |
| iasData | input | 16 | New handler address |
| iaqValid | input | 1 | Set or clear the hold flag |
| iaqArg | input | 16 | Hold argument; nonzero sets the flag, zero clears it |
| rfiValid | input | 1 | Return from interrupt; clears the hold flag |
| stackAck | input | 1 | Core has done the requested stack write |
| stackPushReq | output | 1 | Request to write `stackPushData` to the stack |
| stackPushData | output | 16 | Word to write to the stack |
| loadValid | output | 1 | Load `newPc` and `newA` into the core |
| newPc | output | 16 | Handler address for the program counter |
| newA | output | 16 | Interrupt message for the accumulator |
| iaValue | output | 16 | Current handler address, for the read command |
| inService | output | 1 | An entry sequence is running |
| overflow | output | 1 | Sticky flag: a message was lost because the queue was full |

## Verification
The hardest case to reach is the full queue. The bench only gets there because the hold flag stops any removal while 256 messages are queued, and one more message is then pushed to raise the overflow. The queue is then drained, one entry sequence and one return at a time. This confirms that all 256 messages leave in order and that the extra message is gone. Two other cases need a set order of steps and are driven that way. In one, a message is queued while the handler address is zero and the address is changed before the boundary. In the other, a software and a hardware message are pushed in the same cycle while the flag holds the queue.

// File: rtl/irq_queue_pkg.sv
package irq_queue_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_PUSH_PC = 2'd1,
    ST_PUSH_A  = 2'd2,
    ST_LOAD    = 2'd3
  } entryState_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic take;      // remove the head entry of the queue
    logic enter;     // start an entry: latch context, set hold flag
    logic pushSelA;  // stack word is the saved accumulator
  } intStrobe_t;

endpackage

// File: rtl/irq_queue_dp.sv
module irq_queue_dp
  import irq_queue_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 256
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         swPush,
  input  logic [W-1:0] swMsg,
  input  logic         hwPush,
  input  logic [W-1:0] hwMsg,
  input  logic [W-1:0] pcIn,
  input  logic [W-1:0] aIn,
  input  logic         iasValid,
  input  logic [W-1:0] iasData,
  input  logic         iaqValid,
  input  logic [W-1:0] iaqArg,
  input  logic         rfiValid,
  input  intStrobe_t   strobe,
  output logic         fifoEmpty,
  output logic         queueingOn,
  output logic         iaZero,
  output logic [W-1:0] iaValue,
  output logic [W-1:0] pushWord,
  output logic [W-1:0] savedIa,
  output logic [W-1:0] savedMsg,
  output logic         overflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rdPtr, wrPtr;
  logic [CW-1:0] count, space, nAcc;
  logic          slot0Valid, slot1Valid, acc0, acc1, dropAny;
  logic [W-1:0]  slot0Data, ia, savedPc, savedA;

  always_comb begin
    space      = CW'(DEPTH) - count;
    slot0Valid = swPush | hwPush;
    slot0Data  = swPush ? swMsg : hwMsg;
    slot1Valid = swPush & hwPush;
    acc0       = slot0Valid && (space >= CW'(1));
    acc1       = slot1Valid && (space >= CW'(2));
    dropAny    = (slot0Valid && !acc0) || (slot1Valid && !acc1);
    nAcc       = CW'(acc0) + CW'(acc1);
  end

  always_ff @(posedge clk) begin
    if (acc0) mem[wrPtr] <= slot0Data;
    if (acc1) mem[wrPtr + AW'(1)] <= hwMsg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr      <= '0;
      wrPtr      <= '0;
      count      <= '0;
      overflow   <= 1'b0;
      ia         <= '0;
      queueingOn <= 1'b0;
      savedPc    <= '0;
      savedA     <= '0;
      savedIa    <= '0;
      savedMsg   <= '0;
    end else begin
      wrPtr <= wrPtr + AW'(nAcc);
      rdPtr <= rdPtr + AW'(strobe.take);
      count <= count + nAcc - CW'(strobe.take);
      if (dropAny) overflow <= 1'b1;
      if (iasValid) ia <= iasData;
      if (strobe.enter)  queueingOn <= 1'b1;
      else if (iaqValid) queueingOn <= (iaqArg != '0);
      else if (rfiValid) queueingOn <= 1'b0;
      if (strobe.enter) begin
        savedPc  <= pcIn;
        savedA   <= aIn;
        savedIa  <= ia;
        savedMsg <= mem[rdPtr];
      end
    end
  end

  assign fifoEmpty = (count == '0);
  assign iaZero    = (ia == '0);
  assign iaValue   = ia;
  assign pushWord  = strobe.pushSelA ? savedA : savedPc;

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));
  assert_overflow_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);
  assert_entry_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.enter |=> queueingOn);
  assert_take_nonempty_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |-> !fifoEmpty);

endmodule

// File: rtl/irq_queue_fsm.sv
module irq_queue_fsm
  import irq_queue_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       atBoundary,
  input  logic       fifoEmpty,
  input  logic       queueingOn,
  input  logic       iaZero,
  input  logic       stackAck,
  output intStrobe_t strobe,
  output logic       stackPushReq,
  output logic       loadValid,
  output logic       inService
);
  entryState_t state, stateNext;
  logic canTake;

  always_comb begin
    canTake         = atBoundary && !fifoEmpty && !queueingOn && (state == ST_IDLE);
    strobe.take     = canTake;
    strobe.enter    = canTake && !iaZero;
    strobe.pushSelA = (state == ST_PUSH_A);
    stateNext       = state;
    unique case (state)
      ST_IDLE:    if (strobe.enter) stateNext = ST_PUSH_PC;
      ST_PUSH_PC: if (stackAck) stateNext = ST_PUSH_A;
      ST_PUSH_A:  if (stackAck) stateNext = ST_LOAD;
      ST_LOAD:    stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign stackPushReq = (state == ST_PUSH_PC) || (state == ST_PUSH_A);
  assign loadValid    = (state == ST_LOAD);
  assign inService    = (state != ST_IDLE);

  assert_req_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stackPushReq && !stackAck) |=> stackPushReq);
  assert_load_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    loadValid |=> !loadValid);
  assert_no_take_held_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |-> !queueingOn);
  assert_no_take_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    inService |-> !strobe.take);

endmodule

// File: rtl/irq_queue_ctrl.sv
module irq_queue_ctrl
  import irq_queue_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 256
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         swPush,
  input  logic [W-1:0] swMsg,
  input  logic         hwPush,
  input  logic [W-1:0] hwMsg,
  input  logic         atBoundary,
  input  logic [W-1:0] pcIn,
  input  logic [W-1:0] aIn,
  input  logic         iasValid,
  input  logic [W-1:0] iasData,
  input  logic         iaqValid,
  input  logic [W-1:0] iaqArg,
  input  logic         rfiValid,
  input  logic         stackAck,
  output logic         stackPushReq,
  output logic [W-1:0] stackPushData,
  output logic         loadValid,
  output logic [W-1:0] newPc,
  output logic [W-1:0] newA,
  output logic [W-1:0] iaValue,
  output logic         inService,
  output logic         overflow
);
  intStrobe_t strobe;
  logic fifoEmpty, queueingOn, iaZero;

  irq_queue_dp #(.W(W), .DEPTH(DEPTH)) uDp (
    .clk(clk), .rstN(rstN),
    .swPush(swPush), .swMsg(swMsg), .hwPush(hwPush), .hwMsg(hwMsg),
    .pcIn(pcIn), .aIn(aIn),
    .iasValid(iasValid), .iasData(iasData),
    .iaqValid(iaqValid), .iaqArg(iaqArg), .rfiValid(rfiValid),
    .strobe(strobe),
    .fifoEmpty(fifoEmpty), .queueingOn(queueingOn), .iaZero(iaZero),
    .iaValue(iaValue), .pushWord(stackPushData),
    .savedIa(newPc), .savedMsg(newA), .overflow(overflow)
  );

  irq_queue_fsm uFsm (
    .clk(clk), .rstN(rstN), .atBoundary(atBoundary),
    .fifoEmpty(fifoEmpty), .queueingOn(queueingOn), .iaZero(iaZero),
    .stackAck(stackAck), .strobe(strobe),
    .stackPushReq(stackPushReq), .loadValid(loadValid), .inService(inService)
  );

  assert_push_load_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(stackPushReq && loadValid));

endmodule

// File: tb/irq_queue_ctrl_test.sv
module irq_queue_ctrl_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic swPush = 0, hwPush = 0, atBoundary = 0, iasValid = 0, iaqValid = 0;
  logic rfiValid = 0, stackAck = 0;
  logic [15:0] swMsg = '0, hwMsg = '0, pcIn = '0, aIn = '0, iasData = '0, iaqArg = '0;
  logic stackPushReq, loadValid, inService, overflow;
  logic [15:0] stackPushData, newPc, newA, iaValue;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_queue_ctrl uut (.*);

  // {handler address, message, pc, a}
  localparam logic [63:0] VEC [4] = '{
    64'h1000_0005_0042_1234,
    64'h2468_FFFF_0100_0000,
    64'h0001_8000_FFFE_ABCD,
    64'hFFFF_0000_7777_5555
  };

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setIa(input logic [15:0] v);
    iasValid = 1; iasData = v;
    @(negedge clk); iasValid = 0;
    chk(iaValue == v, "R2", iaValue, v);
  endtask

  task automatic pushOne(input bit useHw, input logic [15:0] m);
    if (useHw) begin hwPush = 1; hwMsg = m; end
    else begin swPush = 1; swMsg = m; end
    @(negedge clk); swPush = 0; hwPush = 0;
  endtask

  task automatic doRfi();
    rfiValid = 1; @(negedge clk); rfiValid = 0;
  endtask

  task automatic setHold(input logic [15:0] arg);
    iaqValid = 1; iaqArg = arg; @(negedge clk); iaqValid = 0;
  endtask

  task automatic runDispatch(input logic [15:0] ePc, eA, eIa, eMsg, input string req);
    pcIn = ePc; aIn = eA;
    atBoundary = 1; @(negedge clk); atBoundary = 0;
    chk(stackPushReq == 1'b1, req, 16'(stackPushReq), 16'h1);
    chk(stackPushData == ePc, req, stackPushData, ePc);
    stackAck = 1; @(negedge clk);
    chk(stackPushReq == 1'b1, req, 16'(stackPushReq), 16'h1);
    chk(stackPushData == eA, req, stackPushData, eA);
    @(negedge clk); stackAck = 0;
    chk(loadValid == 1'b1, req, 16'(loadValid), 16'h1);
    chk(newPc == eIa, req, newPc, eIa);
    chk(newA == eMsg, req, newA, eMsg);
    @(negedge clk);
    chk(!loadValid && !stackPushReq, req, 16'(loadValid), 16'h0);
  endtask

  task automatic expectNone(input string req);
    atBoundary = 1; @(negedge clk); atBoundary = 0;
    for (int k = 0; k < 3; k++) begin
      chk(!stackPushReq && !loadValid && !inService, req, 16'(stackPushReq), 16'h0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1; @(negedge clk);
    // R1 reset state
    chk(!stackPushReq && !loadValid && !inService, "R1", 16'(stackPushReq), 16'h0);
    chk(!overflow, "R1", 16'(overflow), 16'h0);
    chk(iaValue == 16'h0, "R1", iaValue, 16'h0);

    // Vector table: R2, R5, R6, R8
    for (int i = 0; i < 4; i++) begin
      setIa(VEC[i][63:48]);
      pushOne(i[0], VEC[i][47:32]);
      // R5: no removal without a boundary
      repeat (2) @(negedge clk);
      chk(!stackPushReq && !inService, "R5", 16'(stackPushReq), 16'h0);
      runDispatch(VEC[i][31:16], VEC[i][15:0], VEC[i][63:48], VEC[i][47:32], "R6");
      doRfi();
    end

    // R7 hold after entry, queueing continues; R8 release by return
    setIa(16'h3000);
    pushOne(0, 16'h0A01);
    pushOne(1, 16'h0A02);
    runDispatch(16'h0010, 16'h0020, 16'h3000, 16'h0A01, "R7");
    pushOne(0, 16'h0A03);
    expectNone("R7");
    doRfi();
    runDispatch(16'h0011, 16'h0021, 16'h3000, 16'h0A02, "R8");
    doRfi();
    runDispatch(16'h0012, 16'h0022, 16'h3000, 16'h0A03, "R7");
    doRfi();

    // R4 same-cycle order, R9 hold command
    setHold(16'h0001);
    swPush = 1; swMsg = 16'h1111; hwPush = 1; hwMsg = 16'h2222;
    @(negedge clk); swPush = 0; hwPush = 0;
    expectNone("R9");
    setHold(16'h0000);
    runDispatch(16'h0030, 16'h0040, 16'h3000, 16'h1111, "R4");
    doRfi();
    runDispatch(16'h0031, 16'h0041, 16'h3000, 16'h2222, "R4");
    doRfi();

    // R6 stalled acknowledge keeps request and data
    pushOne(0, 16'h0B0B);
    pcIn = 16'hC0DE; aIn = 16'hBEEF;
    atBoundary = 1; @(negedge clk); atBoundary = 0;
    pcIn = 16'h0; aIn = 16'h0;
    for (int k = 0; k < 2; k++) begin
      chk(stackPushReq && stackPushData == 16'hC0DE, "R6", stackPushData, 16'hC0DE);
      @(negedge clk);
    end
    stackAck = 1; @(negedge clk); stackAck = 0;
    for (int k = 0; k < 2; k++) begin
      chk(stackPushReq && stackPushData == 16'hBEEF, "R6", stackPushData, 16'hBEEF);
      @(negedge clk);
    end
    stackAck = 1; @(negedge clk); stackAck = 0;
    chk(loadValid && newA == 16'h0B0B, "R6", newA, 16'h0B0B);
    @(negedge clk);
    doRfi();

    // R10 zero address discards at removal
    setIa(16'h0000);
    pushOne(0, 16'hAAAA);
    expectNone("R10");
    setIa(16'h4000);
    expectNone("R10");
    // R11 address checked at removal
    setIa(16'h0000);
    pushOne(1, 16'hBBBB);
    setIa(16'h5000);
    runDispatch(16'h0050, 16'h0060, 16'h5000, 16'hBBBB, "R11");
    doRfi();

    // R3 fill queue under hold, then overflow
    setHold(16'h8000);
    for (int i = 0; i < 256; i++) pushOne(i[0], 16'(i));
    chk(!overflow, "R3", 16'(overflow), 16'h0);
    pushOne(0, 16'hFFFF);
    chk(overflow, "R3", 16'(overflow), 16'h1);
    setIa(16'h7000);
    setHold(16'h0000);
    for (int i = 0; i < 256; i++) begin
      runDispatch(16'(i + 1), 16'(i + 2), 16'h7000, 16'(i), "R3");
      doRfi();
    end
    expectNone("R3");
    chk(overflow, "R3", 16'(overflow), 16'h1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule